// File: doc/BRIEF.md
# Byte-wide nonvolatile store programming controller

This block fronts a small byte-addressable nonvolatile data store, modelled here as a bank of registers. Software programs it through four byte-wide registers: an address split into a low and a high byte, a data byte, and a control byte. A store operation takes several steps. Software writes the address and data. It then sets an arming bit. Within a short window it writes the control register again, with the start bit and a two-bit operation code. The controller then runs a timed cycle of fixed length, during which the start bit reads back as 1. At the end of the cycle it commits the result to the addressed byte and raises a ready interrupt, if that interrupt is enabled locally and globally.

The three usable operation codes are a combined erase-and-program, an erase alone and a program alone. Each has its own duration, set by a parameter in clock cycles. The erase and the program can therefore be split: a byte is erased early, and the shorter program-only cycle finishes the job later. A read strobe copies the addressed byte into the data register when the controller is idle.

There are two reset inputs. A power-on reset clears everything and sets every stored byte to 0xFF. A system reset clears the register interface, but it does not abort a cycle that is running. In that case the operation code is kept, so the register still describes the cycle in flight.

Top module: `nvm_byte_ctrl`

Register selects (`wr_sel_i` / `rd_sel_i`): 0 address low byte, 1 address high byte (reads 0 when the store has 256 bytes or fewer), 2 data, 3 control. Control bits: bit 0 read strobe (reads 0), bit 1 start / busy, bit 2 arm, bit 3 ready-interrupt enable, bits 5:4 operation code, bits 7:6 read 0.

## Requirements
- R1: Operation code 00 (erase and program) stores the data byte exactly as given. `busy_o` stays high for T_ATOMIC cycles.
- R2: Operation code 01 (erase only) sets the addressed byte to 0xFF. `busy_o` stays high for T_ERASE cycles.
- R3: Operation code 10 (program only) stores the AND of the old byte and the data byte. `busy_o` stays high for T_WRITE cycles, so an erase followed by a program-only yields the data byte.
- R4: A start write that carries operation code 11 starts no cycle, and `busy_o` stays 0.
- R5: Writing a 1 to control bit 2 arms the controller for ARM_WINDOW (4) clock cycles. A start write is accepted only while the controller is armed, so arm and start cannot share one write. After the window, bit 2 reads 0 again without any action from software.
- R6: While a cycle runs, control writes leave the operation code unchanged.
- R7: A system reset (`rst_n` low) sets the operation code to 00 when the controller is idle. During a cycle it keeps the operation code and lets the cycle finish and commit.
- R8: `irq_o` is high exactly when the ready-interrupt enable is set, `gie_i` is high and no cycle is running.
- R9: A read strobe loads the addressed stored byte into the data register when the controller is idle. While a cycle runs, the strobe is ignored.
- R10: After power-on reset every stored byte is 0xFF, the control register reads 0, and `busy_o` and `irq_o` are 0.
- R11: The start bit (control bit 1) reads 1 for the whole cycle and clears itself when the cycle ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything, including the store |
| rst_n | input | 1 | System reset, active low, synchronous; does not abort a running cycle |
| gie_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register written |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Register read (combinational) |
| rd_data_o | output | 8 | Read data |
| busy_o | output | 1 | Programming cycle in progress |
| irq_o | output | 1 | Ready interrupt request (level) |

## Verification
The main function is tried on a sequence of operations at one address: a combined operation, a program-only that must AND into the earlier value, an erase, and a program-only on the erased byte. Together these separate the three commit rules, and a swap of any two would show up as a wrong byte. Further operations at a fresh address and at a high address check the durations against the operation code, because the long and short cycles differ. Directed cases place the start write on the last accepted cycle of the arming window and on the first rejected one, and pulse the system reset during a cycle and while idle.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

   typedef enum logic [1:0] {
      OP_ATOMIC = 2'b00,
      OP_ERASE  = 2'b01,
      OP_WRITE  = 2'b10,
      OP_RSVD   = 2'b11
   } nvm_op_e;

   localparam logic [1:0] SEL_ADDR_LO = 2'd0;
   localparam logic [1:0] SEL_ADDR_HI = 2'd1;
   localparam logic [1:0] SEL_DATA    = 2'd2;
   localparam logic [1:0] SEL_CTRL    = 2'd3;

   localparam int CB_STROBE = 0;
   localparam int CB_GO     = 1;
   localparam int CB_ARM    = 2;
   localparam int CB_RIE    = 3;
   localparam int CB_MODE   = 4;

   // Result of committing one operation to a stored byte
   function automatic logic [7:0] apply_op(input nvm_op_e op,
                                           input logic [7:0] old_b,
                                           input logic [7:0] new_b);
      case (op)
         OP_ERASE: return 8'hFF;
         OP_WRITE: return old_b & new_b;
         default:  return new_b;
      endcase
   endfunction

endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic rst_n,
   input  logic set_i,
   input  logic consume_i,
   output logic armed_o
);
   localparam int CW = $clog2(WINDOW + 1);

   generate
      if (WINDOW < 1) begin : g_bad_window
         $error("nvm_arm_window: WINDOW must be at least 1");
      end
   endgenerate

   logic [CW-1:0] left_q;
   logic          armed_q;

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         armed_q <= 1'b0;
         left_q  <= '0;
      end else if (consume_i) begin
         armed_q <= 1'b0;
         left_q  <= '0;
      end else if (set_i) begin
         armed_q <= 1'b1;
         left_q  <= CW'(WINDOW);
      end else if (armed_q) begin
         if (left_q == CW'(1)) begin
            armed_q <= 1'b0;
            left_q  <= '0;
         end else begin
            left_q <= left_q - CW'(1);
         end
      end
   end

   assign armed_o = armed_q;

endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
   import nvm_pkg::*;
#(
   parameter int T_ATOMIC = 34,
   parameter int T_ERASE  = 18,
   parameter int T_WRITE  = 18,
   parameter int ADDR_W   = 7
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              start_i,
   input  nvm_op_e           op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        data_i,
   output logic              busy_o,
   output logic              commit_o,
   output nvm_op_e           op_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [7:0]        data_o
);
   localparam int T_LONG = (T_ERASE > T_WRITE) ? T_ERASE : T_WRITE;
   localparam int T_MAX  = (T_ATOMIC > T_LONG) ? T_ATOMIC : T_LONG;
   localparam int CW     = $clog2(T_MAX + 1);

   generate
      if (T_ATOMIC < 1 || T_ERASE < 1 || T_WRITE < 1) begin : g_bad_dur
         $error("nvm_prog_seq: every duration must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0]     left_q;
   logic [CW-1:0]     dur;
   logic              busy_q;
   nvm_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;

   always_comb begin
      case (op_i)
         OP_ERASE: dur = CW'(T_ERASE);
         OP_WRITE: dur = CW'(T_WRITE);
         default:  dur = CW'(T_ATOMIC);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!por_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
         op_q   <= OP_ATOMIC;
         addr_q <= '0;
         data_q <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         left_q <= dur;
         op_q   <= op_i;
         addr_q <= addr_i;
         data_q <= data_i;
      end else if (busy_q) begin
         if (left_q == CW'(1)) begin
            busy_q <= 1'b0;
            left_q <= '0;
         end else begin
            left_q <= left_q - CW'(1);
         end
      end
   end

   assign busy_o   = busy_q;
   assign commit_o = busy_q && (left_q == CW'(1));
   assign op_o     = op_q;
   assign addr_o   = addr_q;
   assign data_o   = data_q;

endmodule

// File: rtl/nvm_store.sv
module nvm_store
   import nvm_pkg::*;
#(
   parameter int BYTES  = 128,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              commit_i,
   input  nvm_op_e           op_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [7:0]        wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [7:0]        rdata_o
);
   logic [7:0] cell_q [BYTES];

   generate
      for (genvar i = 0; i < BYTES; i++) begin : g_cell
         always_ff @(posedge clk) begin
            if (!por_n) begin
               cell_q[i] <= 8'hFF;
            end else if (commit_i && (waddr_i == ADDR_W'(i))) begin
               cell_q[i] <= apply_op(op_i, cell_q[i], wdata_i);
            end
         end
      end
   endgenerate

   assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
   import nvm_pkg::*;
#(
   parameter int STORE_BYTES = 128,
   parameter int T_ATOMIC    = 34,
   parameter int T_ERASE     = 18,
   parameter int T_WRITE     = 18,
   parameter int ARM_WINDOW  = 4
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  logic       gie_i,
   input  logic       wr_en_i,
   input  logic [1:0] wr_sel_i,
   input  logic [7:0] wr_data_i,
   input  logic [1:0] rd_sel_i,
   output logic [7:0] rd_data_o,
   output logic       busy_o,
   output logic       irq_o
);
   localparam int ADDR_W    = $clog2(STORE_BYTES);
   localparam int ADDR_LO_W = (ADDR_W < 8) ? ADDR_W : 8;
   localparam int T_LONG    = (T_ERASE > T_WRITE) ? T_ERASE : T_WRITE;
   localparam int T_MAX     = (T_ATOMIC > T_LONG) ? T_ATOMIC : T_LONG;

   generate
      if (STORE_BYTES != 128 && STORE_BYTES != 256 && STORE_BYTES != 512) begin : g_bad_size
         $error("nvm_byte_ctrl: STORE_BYTES must be 128, 256 or 512");
      end
   endgenerate

   // Register interface decode
   logic    ctrl_wr, go_req, start, arm_set, strobe;
   nvm_op_e wr_mode;
   logic    armed, busy, commit;

   assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);
   assign wr_mode = nvm_op_e'(wr_data_i[CB_MODE+1:CB_MODE]);
   assign go_req  = ctrl_wr && wr_data_i[CB_GO];
   assign start   = rst_n && go_req && armed && !busy && (wr_mode != OP_RSVD);
   assign arm_set = ctrl_wr && wr_data_i[CB_ARM];
   assign strobe  = ctrl_wr && wr_data_i[CB_STROBE] && !busy;

   // Address register, split into byte lanes
   logic [ADDR_LO_W-1:0] addr_lo_q;
   logic [ADDR_W-1:0]    addr;
   logic [7:0]           addr_hi_rd;

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         addr_lo_q <= '0;
      end else if (wr_en_i && (wr_sel_i == SEL_ADDR_LO)) begin
         addr_lo_q <= wr_data_i[ADDR_LO_W-1:0];
      end
   end

   generate
      if (ADDR_W > 8) begin : g_hi
         logic [ADDR_W-9:0] addr_hi_q;
         always_ff @(posedge clk) begin
            if (!por_n || !rst_n) begin
               addr_hi_q <= '0;
            end else if (wr_en_i && (wr_sel_i == SEL_ADDR_HI)) begin
               addr_hi_q <= wr_data_i[ADDR_W-9:0];
            end
         end
         assign addr       = {addr_hi_q, addr_lo_q};
         assign addr_hi_rd = 8'(addr_hi_q);
      end else begin : g_no_hi
         assign addr       = addr_lo_q;
         assign addr_hi_rd = 8'h00;
      end
   endgenerate

   // Data, mode and interrupt enable
   logic [7:0] data_q;
   logic [7:0] store_rdata;
   nvm_op_e    mode_q;
   logic       rie_q;

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         data_q <= '0;
      end else if (strobe) begin
         data_q <= store_rdata;
      end else if (wr_en_i && (wr_sel_i == SEL_DATA)) begin
         data_q <= wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n) begin
         mode_q <= OP_ATOMIC;
      end else if (!rst_n) begin
         if (!busy) mode_q <= OP_ATOMIC;
      end else if (ctrl_wr && !busy) begin
         mode_q <= wr_mode;
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         rie_q <= 1'b0;
      end else if (ctrl_wr) begin
         rie_q <= wr_data_i[CB_RIE];
      end
   end

   // Submodules
   nvm_op_e           seq_op;
   logic [ADDR_W-1:0] seq_addr;
   logic [7:0]        seq_data;

   nvm_arm_window #(.WINDOW(ARM_WINDOW)) u_arm (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .set_i     (arm_set),
      .consume_i (start),
      .armed_o   (armed)
   );

   nvm_prog_seq #(
      .T_ATOMIC (T_ATOMIC),
      .T_ERASE  (T_ERASE),
      .T_WRITE  (T_WRITE),
      .ADDR_W   (ADDR_W)
   ) u_seq (
      .clk      (clk),
      .por_n    (por_n),
      .start_i  (start),
      .op_i     (wr_mode),
      .addr_i   (addr),
      .data_i   (data_q),
      .busy_o   (busy),
      .commit_o (commit),
      .op_o     (seq_op),
      .addr_o   (seq_addr),
      .data_o   (seq_data)
   );

   nvm_store #(.BYTES(STORE_BYTES), .ADDR_W(ADDR_W)) u_store (
      .clk      (clk),
      .por_n    (por_n),
      .commit_i (commit),
      .op_i     (seq_op),
      .waddr_i  (seq_addr),
      .wdata_i  (seq_data),
      .raddr_i  (addr),
      .rdata_o  (store_rdata)
   );

   // Read mux and outputs
   always_comb begin
      case (rd_sel_i)
         SEL_ADDR_LO: rd_data_o = 8'(addr_lo_q);
         SEL_ADDR_HI: rd_data_o = addr_hi_rd;
         SEL_DATA:    rd_data_o = data_q;
         default:     rd_data_o = {2'b00, mode_q, rie_q, armed, busy, 1'b0};
      endcase
   end

   assign busy_o = busy;
   assign irq_o  = rie_q && gie_i && !busy;

endmodule

// File: rtl/nvm_byte_ctrl_chk.sv
module nvm_byte_ctrl_chk #(
   parameter int T_ATOMIC = 34,
   parameter int T_ERASE  = 18,
   parameter int T_WRITE  = 18,
   parameter int T_MAX    = 34
) (
   input logic       clk,
   input logic       por_n,
   input logic       rst_n,
   input logic       gie_i,
   input logic       wr_en_i,
   input logic [1:0] wr_sel_i,
   input logic       strobe_bit_i,
   input logic       busy_i,
   input logic       irq_i,
   input logic       armed_i,
   input logic [1:0] mode_i,
   input logic [7:0] data_i
);
   logic [31:0] run_q;

   always_ff @(posedge clk) begin
      if (!por_n)      run_q <= '0;
      else if (busy_i) run_q <= run_q + 32'd1;
      else             run_q <= '0;
   end

   // R1 R2 R3
   cycle_len_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(busy_i) |-> (run_q == 32'(T_ATOMIC) || run_q == 32'(T_ERASE) || run_q == 32'(T_WRITE)));

   // R11
   run_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
      run_q <= 32'(T_MAX));

   // R5
   arm_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(busy_i) |-> $past(armed_i));

   // R6
   mode_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
      (busy_i && $past(busy_i)) |-> $stable(mode_i));

   // R7
   reset_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n && busy_i) |=> (mode_i == $past(mode_i)));

   // R8
   irq_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
      (busy_i || !gie_i) |-> !irq_i);

   // R9
   strobe_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
      (busy_i && wr_en_i && wr_sel_i == 2'd3 && strobe_bit_i) |=> $stable(data_i));

endmodule

bind nvm_byte_ctrl nvm_byte_ctrl_chk #(
   .T_ATOMIC (T_ATOMIC),
   .T_ERASE  (T_ERASE),
   .T_WRITE  (T_WRITE),
   .T_MAX    (T_MAX)
) u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .rst_n        (rst_n),
   .gie_i        (gie_i),
   .wr_en_i      (wr_en_i),
   .wr_sel_i     (wr_sel_i),
   .strobe_bit_i (wr_data_i[0]),
   .busy_i       (busy),
   .irq_i        (irq_o),
   .armed_i      (armed),
   .mode_i       (mode_q),
   .data_i       (data_q)
);

// File: tb/nvm_byte_ctrl_tb.sv
module nvm_byte_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TA = 34;
   localparam int TE = 18;
   localparam int TW = 18;

   // {mode, addr, data, expected byte}
   localparam logic [25:0] VEC [0:6] = '{
      {2'b00, 8'd5,   8'h3C, 8'h3C},
      {2'b10, 8'd5,   8'hF0, 8'h30},
      {2'b01, 8'd5,   8'h00, 8'hFF},
      {2'b10, 8'd5,   8'hA5, 8'hA5},
      {2'b00, 8'd100, 8'h00, 8'h00},
      {2'b10, 8'd9,   8'h5A, 8'h5A},
      {2'b01, 8'd127, 8'h12, 8'hFF}
   };

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       rst_n = 1'b1;
   logic       gie = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_sel = 2'd0;
   logic [7:0] rd_data;
   logic       busy, irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_byte_ctrl #(.STORE_BYTES(128), .T_ATOMIC(TA), .T_ERASE(TE), .T_WRITE(TW),
                   .ARM_WINDOW(4)) u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .gie_i(gie),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .rd_sel_i(rd_sel), .rd_data_o(rd_data), .busy_o(busy), .irq_o(irq));

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [7:0] v);
      rd_sel = sel;
      #1;
      v = rd_data;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic fetch(input logic [7:0] a, output logic [7:0] v);
      wr(2'd0, a);
      wr(2'd3, 8'h01);
      rd(2'd2, v);
   endtask

   function automatic int dur_of(input logic [1:0] m);
      return (m == 2'b00) ? TA : (m == 2'b01) ? TE : TW;
   endfunction

   // address, data, arm, start; returns at the negedge after the start edge
   task automatic launch(input logic [1:0] m, input logic [7:0] a, input logic [7:0] d,
                         input logic rie);
      wr(2'd0, a);
      wr(2'd2, d);
      wr(2'd3, {2'b00, m, rie, 3'b100});
      wr(2'd3, {2'b00, m, rie, 3'b010});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      // R10 power-on state
      check("R10 busy", busy, 0);
      check("R10 irq", irq, 0);
      rd(2'd3, v); check("R10 ctrl", v, 8'h00);
      fetch(8'd77, v); check("R10 store erased", v, 8'hFF);

      // R1 R2 R3 R11 vector walk
      for (int i = 0; i < 7; i++) begin
         launch(VEC[i][25:24], VEC[i][23:16], VEC[i][15:8], 1'b0);
         rd(2'd3, v); check("R11 start bit while busy", v[1], 1);
         wait_idle(n);
         check($sformatf("R1/R2/R3 duration vec %0d", i), n, dur_of(VEC[i][25:24]));
         rd(2'd3, v); check("R11 start bit clears", v[1], 0);
         fetch(VEC[i][23:16], v);
         check($sformatf("R1/R2/R3 byte vec %0d", i), v, VEC[i][7:0]);
      end

      // R4 reserved code
      wr(2'd3, 8'h34);
      wr(2'd3, 8'h32);
      check("R4 reserved starts nothing", busy, 0);

      // R5 arm readback and window
      wr(2'd3, 8'h04);
      repeat (3) @(negedge clk);
      rd(2'd3, v); check("R5 armed inside window", v[2], 1);
      @(negedge clk);
      rd(2'd3, v); check("R5 arm self-clears", v[2], 0);
      wr(2'd0, 8'd40); wr(2'd2, 8'h11);
      wr(2'd3, 8'h24);
      repeat (2) @(negedge clk);
      wr(2'd3, 8'h22);
      check("R5 start on last window cycle", busy, 1);
      wait_idle(n);
      wr(2'd3, 8'h24);
      repeat (3) @(negedge clk);
      wr(2'd3, 8'h22);
      check("R5 start after window rejected", busy, 0);
      wr(2'd3, 8'h26);
      check("R5 arm and start in one write rejected", busy, 0);

      // R6 R9 while busy
      launch(2'b10, 8'd20, 8'h0F, 1'b0);
      wr(2'd3, 8'h10);
      rd(2'd3, v); check("R6 mode locked while busy", v[5:4], 2'b10);
      wr(2'd2, 8'h77);
      wr(2'd3, 8'h21);
      rd(2'd2, v); check("R9 strobe ignored while busy", v, 8'h77);
      check("R6 still busy during checks", busy, 1);
      wait_idle(n);
      fetch(8'd20, v); check("R3 program-only on erased byte", v, 8'h0F);

      // R7 system reset during a cycle and while idle
      launch(2'b10, 8'd30, 8'h3C, 1'b0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(2'd3, v); check("R7 mode kept in reset while busy", v[5:4], 2'b10);
      check("R7 cycle survives reset", busy, 1);
      wait_idle(n);
      fetch(8'd30, v); check("R7 cycle committed", v, 8'h3C);
      wr(2'd3, 8'h10);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(2'd3, v); check("R7 mode cleared in reset while idle", v[5:4], 2'b00);

      // R8 ready interrupt gating
      wr(2'd3, 8'h08);
      gie = 1'b0; #1;
      check("R8 irq off without global enable", irq, 0);
      gie = 1'b1; #1;
      check("R8 irq on when idle and enabled", irq, 1);
      launch(2'b01, 8'd50, 8'h00, 1'b1);
      check("R8 irq low while busy", irq, 0);
      wait_idle(n);
      check("R8 irq high when ready", irq, 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule